// File: doc/BRIEF.md
# CAN Bit Timing Generator

The block divides the system clock into time quanta and arranges those quanta into CAN bit times. Each bit time has three parts: a sync quantum, a first phase segment and a second phase segment. The block marks where the receiver samples the bus, where the transmitter may launch the next bit, and the value of the received bit. It follows the bus by watching the receive line for recessive-to-dominant (1 to 0) transitions. A transition normally causes a bounded resynchronisation. When the frame logic requests it, the transition instead restarts the bit (hard synchronisation).

The timing settings are a prescaler, a jump width, two segment lengths and a triple-sampling select. They are loaded only while the reset-mode input is high. While reset mode is high, the generator stands still, and it starts a fresh bit when reset mode falls. The frame logic uses `sample_o` together with `rx_bit_o` to collect bits, and uses `tx_pt_o` to change its transmit level.

Top module: `can_bit_timer`

## Requirements
- R1: While operating, `tq_o` pulses for one clock every P clocks, where P is the captured prescaler value; a prescaler of 0 behaves as 1.
- R2: While `reset_mode_i` is high, `tq_o`, `sample_o` and `tx_pt_o` stay low, the timing inputs are captured, and from the next clock `rx_bit_o` reads 1 and a new bit begins with its sync quantum. Changes to the timing inputs while `reset_mode_i` is low have no effect.
- R3: Without bus edges, a bit lasts 1 + (tseg1+1) + (tseg2+1) quanta. `sample_o` pulses on the quantum tick that ends the first phase segment. `tx_pt_o` pulses on the tick that ends the second phase segment. The next quantum is the sync quantum of the next bit.
- R4: An edge is a quantum tick where `rx_i` is 0 and `rx_i` was 1 at the previous tick. An edge on the k-th quantum of the first phase segment (k counted from 1) lengthens that segment by min(k, sjw+1) quanta.
- R5: Consider an edge on a quantum of the second phase segment that has r quanta still to follow in that segment. If r ≤ sjw+1, the bit ends on that tick. Otherwise the segment is shortened by sjw+1 quanta.
- R6: At most one resynchronisation is applied per bit. An edge on the sync quantum causes no adjustment.
- R7: An edge while `hard_sync_i` is high makes its quantum the sync quantum, so the next quantum is the first quantum of the first phase segment. `sample_o` and `tx_pt_o` stay low on that tick, and no resynchronisation is applied for the rest of that bit.
- R8: `rx_bit_o` updates in the clock after `sample_o`. With `triple_i` at 0 it takes `rx_i` at the sample tick. With `triple_i` at 1 it takes the majority of `rx_i` at the sample tick and at the two quantum ticks before it.
- R9: `sample_o` and `tx_pt_o` only pulse in clocks where `tq_o` is high, and never both in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_mode_i | input | 1 | Controller reset mode; loads timing inputs and holds the generator |
| brp_i | input | 9 | Prescaler, system clocks per quantum |
| sjw_i | input | 2 | Jump width field, limit is field+1 quanta |
| tseg1_i | input | 6 | First phase segment field, length is field+1 quanta |
| tseg2_i | input | 5 | Second phase segment field, length is field+1 quanta |
| triple_i | input | 1 | 1 selects three-sample majority |
| rx_i | input | 1 | Raw receive line, 1 recessive |
| hard_sync_i | input | 1 | Next edge restarts the bit instead of resynchronising |
| tq_o | output | 1 | Quantum tick, one clock wide |
| sample_o | output | 1 | Sample point strobe |
| tx_pt_o | output | 1 | End of bit, transmit point strobe |
| rx_bit_o | output | 1 | Last sampled bit value |

## Verification
The critical coincidence is a bus edge that falls on the quantum that would otherwise be the sample point or the end of the bit. On such a tick, a resynchronisation must move the sample point or end the bit early, and a hard sync must suppress both strobes. These cases are provoked by random receive toggling and random hard-sync requests. The runs use short segments and prescalers of 0 and 1, so edges land on every quantum position. Every clock is compared against a quantum-position model in the bench, which derives the lengthened or shortened segment from the requirements.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PSC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic [PSC_W-1:0] brp_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] last;

  // zero prescaler treated as divide-by-one
  assign last   = (brp_i == '0) ? '0 : brp_i - PSC_W'(1);
  assign tick_o = !hold_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (hold_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + PSC_W'(1);
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic tick_i,
  input  logic rx_i,
  input  logic triple_i,
  input  logic take_i,
  output logic edge_o,
  output logic bit_o
);
  logic       rx_last_q;
  logic [1:0] hist_q;
  logic       bit_q;
  logic       vote;

  assign edge_o = tick_i && rx_last_q && !rx_i;
  assign vote   = (rx_i & hist_q[0]) | (rx_i & hist_q[1]) | (hist_q[0] & hist_q[1]);
  assign bit_o  = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_last_q <= 1'b1;
      hist_q    <= 2'b11;
      bit_q     <= 1'b1;
    end else if (hold_i) begin
      rx_last_q <= 1'b1;
      hist_q    <= 2'b11;
      bit_q     <= 1'b1;
    end else if (tick_i) begin
      rx_last_q <= rx_i;
      hist_q    <= {hist_q[0], rx_i};
      if (take_i) bit_q <= triple_i ? vote : rx_i;
    end
  end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq import can_bt_pkg::*; #(
  parameter int SJW_W = 2,
  parameter int TS1_W = 6,
  parameter int TS2_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             hs_en_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic [TS1_W-1:0] tseg1_i,
  input  logic [TS2_W-1:0] tseg2_i,
  output logic             sample_o,
  output logic             txpt_o
);
  localparam int MAXW = (TS1_W > TS2_W) ? TS1_W : TS2_W;
  localparam int EW   = SJW_W + 1;
  localparam int CW   = ((MAXW > EW) ? MAXW : EW) + 2;

  seg_e          seg_q;
  logic [CW-1:0] cnt_q;
  logic [EW-1:0] ext_q;
  logic          shrt_q;
  logic          done_q;

  logic [EW-1:0] sjw_p1;
  logic [EW-1:0] ext_n;
  logic [CW-1:0] err1, ts1_end, rem, ts2_lim;
  logic          hard, rs, ts1_last, ts2_last, end_now;

  assign sjw_p1 = EW'(sjw_i) + EW'(1);
  assign hard   = edge_i && hs_en_i;
  assign rs     = edge_i && !done_q && !hard;
  assign err1   = cnt_q + CW'(1);

  // lengthening of the first phase segment
  always_comb begin
    ext_n = ext_q;
    if (rs && seg_q == SEG_TS1)
      ext_n = (err1 < CW'(sjw_p1)) ? EW'(err1) : sjw_p1;
  end

  assign ts1_end  = CW'(tseg1_i) + CW'(ext_n);
  assign ts1_last = (seg_q == SEG_TS1) && (cnt_q == ts1_end);

  // shortening of the second phase segment
  assign rem      = CW'(tseg2_i) - cnt_q;
  assign end_now  = rs && (rem <= CW'(sjw_p1));
  assign ts2_lim  = shrt_q ? CW'(tseg2_i) - CW'(sjw_p1) : CW'(tseg2_i);
  assign ts2_last = (seg_q == SEG_TS2) && (end_now || cnt_q == ts2_lim);

  assign sample_o = tick_i && !hard && ts1_last;
  assign txpt_o   = tick_i && !hard && ts2_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      shrt_q <= 1'b0;
      done_q <= 1'b0;
    end else if (hold_i) begin
      seg_q  <= SEG_SYNC;
      cnt_q  <= '0;
      ext_q  <= '0;
      shrt_q <= 1'b0;
      done_q <= 1'b0;
    end else if (tick_i) begin
      if (hard) begin
        seg_q  <= SEG_TS1;
        cnt_q  <= '0;
        ext_q  <= '0;
        shrt_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_TS1;
            cnt_q <= '0;
          end
          SEG_TS1: begin
            ext_q <= ext_n;
            if (rs) done_q <= 1'b1;
            if (ts1_last) begin
              seg_q <= SEG_TS2;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
            end
          end
          SEG_TS2: begin
            if (ts2_last) begin
              seg_q  <= SEG_SYNC;
              cnt_q  <= '0;
              ext_q  <= '0;
              shrt_q <= 1'b0;
              done_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q + CW'(1);
              if (rs) begin
                shrt_q <= 1'b1;
                done_q <= 1'b1;
              end
            end
          end
          default: seg_q <= SEG_SYNC;
        endcase
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PSC_W = 9,
  parameter int SJW_W = 2,
  parameter int TS1_W = 6,
  parameter int TS2_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_mode_i,
  input  logic [PSC_W-1:0] brp_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic [TS1_W-1:0] tseg1_i,
  input  logic [TS2_W-1:0] tseg2_i,
  input  logic             triple_i,
  input  logic             rx_i,
  input  logic             hard_sync_i,
  output logic             tq_o,
  output logic             sample_o,
  output logic             tx_pt_o,
  output logic             rx_bit_o
);
  logic [PSC_W-1:0] brp_q;
  logic [SJW_W-1:0] sjw_q;
  logic [TS1_W-1:0] tseg1_q;
  logic [TS2_W-1:0] tseg2_q;
  logic             triple_q;
  logic             tick, edge_det, smp;

  // timing settings load only in reset mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brp_q    <= '0;
      sjw_q    <= '0;
      tseg1_q  <= '0;
      tseg2_q  <= '0;
      triple_q <= 1'b0;
    end else if (reset_mode_i) begin
      brp_q    <= brp_i;
      sjw_q    <= sjw_i;
      tseg1_q  <= tseg1_i;
      tseg2_q  <= tseg2_i;
      triple_q <= triple_i;
    end
  end

  can_bt_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (reset_mode_i),
    .brp_i  (brp_q),
    .tick_o (tick)
  );

  can_bt_sampler i_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (reset_mode_i),
    .tick_i   (tick),
    .rx_i     (rx_i),
    .triple_i (triple_q),
    .take_i   (smp),
    .edge_o   (edge_det),
    .bit_o    (rx_bit_o)
  );

  can_bt_seq #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (reset_mode_i),
    .tick_i   (tick),
    .edge_i   (edge_det),
    .hs_en_i  (hard_sync_i),
    .sjw_i    (sjw_q),
    .tseg1_i  (tseg1_q),
    .tseg2_i  (tseg2_q),
    .sample_o (smp),
    .txpt_o   (tx_pt_o)
  );

  assign tq_o     = tick;
  assign sample_o = smp;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int PSC_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reset_mode_i,
  input logic             tq_o,
  input logic             sample_o,
  input logic             tx_pt_o,
  input logic             rx_bit_o,
  input logic [PSC_W-1:0] brp_q
);
  assert_sample_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> tq_o);

  assert_txpt_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pt_o |-> tq_o);

  assert_strobes_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && tx_pt_o));

  assert_quiet_in_reset_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_mode_i |-> !tq_o && !sample_o && !tx_pt_o);

  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_o && brp_q > PSC_W'(1)) |=> !tq_o);

  assert_bit_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_o && !reset_mode_i) |=> $stable(rx_bit_o));
endmodule

bind can_bit_timer can_bit_timer_chk #(.PSC_W(PSC_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reset_mode_i (reset_mode_i),
  .tq_o         (tq_o),
  .sample_o     (sample_o),
  .tx_pt_o      (tx_pt_o),
  .rx_bit_o     (rx_bit_o),
  .brp_q        (brp_q)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rm = 1'b1;
  logic [8:0] brp = '0;
  logic [1:0] sjw = '0;
  logic [5:0] t1 = '0;
  logic [4:0] t2 = '0;
  logic       tri_s = 1'b0;
  logic       rx = 1'b1;
  logic       hs = 1'b0;
  logic       tq, smp, txp, rbit;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string tag_s = "R3";
  string tag_t = "R3";
  string tag_q = "R1";

  // reference model state
  int m_brp = 0, m_sjw = 0, m_t1 = 0, m_t2 = 0;
  bit m_tri = 0;
  int m_psc = 0, m_q = 0, m_ext = 0;
  bit m_sh = 0, m_done = 0, m_prev = 1, m_h0 = 1, m_h1 = 1, m_bit = 1;

  always #10 clk = ~clk;

  can_bit_timer i_can_bit_timer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reset_mode_i (rm),
    .brp_i        (brp),
    .sjw_i        (sjw),
    .tseg1_i      (t1),
    .tseg2_i      (t2),
    .triple_i     (tri_s),
    .rx_i         (rx),
    .hard_sync_i  (hs),
    .tq_o         (tq),
    .sample_o     (smp),
    .tx_pt_o      (txp),
    .rx_bit_o     (rbit)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // compare one clock against the model, then advance the model over the next edge
  task automatic step_cycle();
    int  bq, s, t1e, ext_n, t1e_n, nom_end, endn;
    bit  tick, edg, hard, ok, in1, in2, e_s, e_t, sh_n, vote;
    #1;
    chk("R8", rbit, m_bit);
    chk("R9", smp && txp, 1'b0);
    if (rm) begin
      chk("R2", tq, 1'b0);
      chk("R2", smp, 1'b0);
      chk("R2", txp, 1'b0);
      m_brp = brp; m_sjw = sjw; m_t1 = t1; m_t2 = t2; m_tri = tri_s;
      m_psc = 0; m_q = 0; m_ext = 0; m_sh = 0; m_done = 0;
      m_prev = 1; m_h0 = 1; m_h1 = 1; m_bit = 1;
      return;
    end
    bq    = (m_brp == 0) ? 1 : m_brp;
    s     = m_sjw + 1;
    tick  = (m_psc == bq - 1);
    edg   = tick && m_prev && !rx;
    hard  = edg && hs;
    ok    = edg && !m_done && !hard;
    t1e   = m_t1 + 1 + m_ext;
    in1   = (m_q >= 1) && (m_q <= t1e);
    in2   = (m_q > t1e);
    ext_n = m_ext;
    if (ok && in1) ext_n = imin(m_q, s);          // R4
    t1e_n = m_t1 + 1 + ext_n;
    e_s   = tick && !hard && in1 && (m_q == t1e_n);
    nom_end = t1e + m_t2 + 1;
    endn  = m_sh ? nom_end - s : nom_end;
    sh_n  = m_sh;
    if (ok && in2) begin                          // R5
      if (nom_end - m_q <= s) endn = m_q;
      else begin endn = nom_end - s; sh_n = 1; end
    end
    e_t = tick && !hard && in2 && (m_q == endn);
    chk(tag_q, tq, tick);
    chk(tag_s, smp, e_s);
    chk(tag_t, txp, e_t);
    if (!tick) begin
      m_psc++;
      return;
    end
    m_psc = 0;
    vote = (rx & m_h0) | (rx & m_h1) | (m_h0 & m_h1);
    if (e_s) m_bit = m_tri ? vote : rx;
    m_h1 = m_h0; m_h0 = rx; m_prev = rx;
    if (hard) begin                               // R7
      m_q = 1; m_ext = 0; m_sh = 0; m_done = 1;
    end else if (m_q == 0) begin
      m_q = 1;
    end else if (in1) begin
      m_ext = ext_n;
      if (ok) m_done = 1;                         // R6
      m_q++;
    end else begin
      if (m_q == endn) begin
        m_q = 0; m_ext = 0; m_sh = 0; m_done = 0;
      end else begin
        m_q++;
        if (ok) begin m_sh = sh_n; m_done = 1; end
      end
    end
  endtask

  task automatic configure(int b, int j, int a, int c, bit tr);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rm = 1'b1; brp = 9'(b); sjw = 2'(j); t1 = 6'(a); t2 = 5'(c);
      tri_s = tr; rx = 1'b1; hs = 1'b0;
      step_cycle();
    end
  endtask

  task automatic run(int n, int p_tog, int p_hs, bit scramble);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rm = 1'b0;
      if (($urandom % 100) < p_tog) rx = ~rx;
      hs = (($urandom % 100) < p_hs);
      if (scramble) begin
        brp = 9'($urandom); sjw = 2'($urandom); t1 = 6'($urandom);
        t2 = 5'($urandom); tri_s = 1'($urandom);
      end
      step_cycle();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    configure(3, 1, 5, 3, 0);
    chk("R2", rbit, 1'b1);
    // R3 nominal bits, quiet bus
    tag_s = "R3"; tag_t = "R3";
    run(600, 0, 0, 0);
    // R1 prescaler 0 and 1
    tag_q = "R1";
    configure(0, 0, 2, 2, 0);
    run(300, 0, 0, 0);
    configure(1, 3, 0, 0, 0);
    run(300, 0, 0, 0);
    // R4 and R5 sparse edges, long second segment for partial shortening
    tag_s = "R4"; tag_t = "R5";
    configure(1, 1, 6, 12, 0);
    run(2500, 8, 0, 0);
    configure(2, 2, 4, 9, 0);
    run(2500, 5, 0, 0);
    // R6 dense edges: several per bit, only one may act
    tag_s = "R6"; tag_t = "R6";
    configure(1, 0, 5, 7, 0);
    run(2000, 30, 0, 0);
    // R7 hard sync mixed with resync
    tag_s = "R7"; tag_t = "R7";
    configure(1, 1, 3, 4, 0);
    run(2000, 15, 30, 0);
    configure(0, 2, 1, 1, 0);
    run(1500, 20, 50, 0);
    // R8 triple sampling with glitches
    tag_s = "R8"; tag_t = "R8";
    configure(2, 1, 4, 3, 1);
    run(2500, 25, 0, 0);
    // R2 timing inputs scrambled outside reset mode
    tag_s = "R2"; tag_t = "R2"; tag_q = "R2";
    configure(3, 1, 3, 2, 0);
    run(2000, 10, 5, 1);
    // random configurations
    tag_q = "R1"; tag_s = "R4"; tag_t = "R5";
    for (int k = 0; k < 8; k++) begin
      configure($urandom % 4, $urandom % 4, $urandom % 10, $urandom % 12, 1'($urandom));
      run(1500, 1 + $urandom % 20, $urandom % 10, 0);
    end
    // long segments at the field limits
    tag_s = "R3"; tag_t = "R3";
    configure(0, 3, 63, 31, 0);
    run(1500, 2, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule